// File: doc/BRIEF.md
# Nested Stream Index Counter

This block watches a stream of samples and labels each valid sample with a set of nested loop indices. It is useful wherever a position inside a frame is needed, for example to pick a coefficient for each sample. The counters form a cascade. The innermost level moves on every valid sample. Each outer level moves only when every level inside it rolls over in the same sample. Each level has its own start value, exclusive stop value and step. These are fixed by parameters.

The sample passes through one register stage without change. The index set that belongs to the sample leaves on the same cycle as the sample. A packed address is formed from two levels that are not next to each other. The low part of the outermost index sits above the low part of the innermost index. In the default setup, the inner level is a two-way polarisation select and the outer level is an 88-entry channel index. This gives addresses 0 to 175, with even addresses for the first polarisation and odd addresses for the second.

Top module: `nest_idx_counter`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, out_valid is 0 and every index field of out_cnt is 0. The first valid sample after reset carries all levels at their start values, which are 0 by default.
- R2: A cycle with in_valid low changes no index. The next valid sample continues exactly where the previous one stopped, however long the gap.
- R3: Level 0 (out_cnt bits [19:0]) counts 0, 1, 0, 1, … on consecutive valid samples. It never reaches its stop value of 2.
- R4: Level 1 (out_cnt bits [39:20]) increases by one only on a sample where level 0 rolls over. It returns to 0 after 99, because its stop value is 100.
- R5: Level 2 (out_cnt bits [59:40]) increases by one only on a sample where levels 0 and 1 both roll over. It returns to 0 after 87. After 2·100·88 = 17600 valid samples, the whole index set is back to all zeros.
- R6: out_valid and out_data equal in_valid and in_data of the previous cycle, whatever the data pattern.
- R7: out_addr equals (level 2 mod 128)·2 + (level 0 mod 2). Bit 0 is the inner index and bits 7..1 are the outer index. On valid output it stays within 0..175.
- R8: out_cnt and out_addr on a valid output cycle describe the sample shown on out_data in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample valid |
| in_data | input | 16 | Input sample payload |
| out_valid | output | 1 | Registered copy of in_valid |
| out_data | output | 16 | Registered copy of in_data |
| out_cnt | output | 60 | Index set of the output sample, 20 bits per level, level 0 in the low bits |
| out_addr | output | 8 | Interleaved address {level 2 low bits, level 0 low bit} |

## Verification
If a level holds a wrong value, the error shows on out_cnt with the very next valid sample. For the outer levels it can also appear only when they next advance, up to 200 samples later for level 2. A missed or extra carry shifts every later index set. The bench therefore runs one full 17600-sample period and checks that it ends at all zeros. A counter that moves on idle cycles is caught by the first sample that follows a gap. A bad address packing is visible on every valid cycle.

// File: rtl/nic_pkg.sv
package nic_pkg;
    localparam int NIC_LVLS   = 3;
    localparam int NIC_CNT_W  = 20;
    localparam int NIC_DATA_W = 16;
    // level 0 in the low word; stop is exclusive
    localparam logic [NIC_LVLS-1:0][31:0] NIC_DEF_START = {32'd0, 32'd0, 32'd0};
    localparam logic [NIC_LVLS-1:0][31:0] NIC_DEF_STOP  = {32'd88, 32'd100, 32'd2};
    localparam logic [NIC_LVLS-1:0][31:0] NIC_DEF_STEP  = {32'd1, 32'd1, 32'd1};
endpackage

// File: rtl/nic_level.sv
module nic_level #(
    parameter int CNT_W = 20,
    parameter int START = 0,
    parameter int STOP  = 2,
    parameter int STEP  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    localparam logic [CNT_W:0] START_X = (CNT_W+1)'(START);
    localparam logic [CNT_W:0] STOP_X  = (CNT_W+1)'(STOP);
    localparam logic [CNT_W:0] STEP_X  = (CNT_W+1)'(STEP);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } lvl_st_t;

    lvl_st_t        st_d, st_q;
    logic [CNT_W:0] sum_d;
    logic           wrap_d;

    always_comb begin
        st_d   = st_q;
        sum_d  = {1'b0, st_q.cnt} + STEP_X;
        wrap_d = adv_i && (sum_d >= STOP_X);
        if (adv_i) begin
            st_d.cnt = wrap_d ? START_X[CNT_W-1:0] : sum_d[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.cnt <= START_X[CNT_W-1:0];
        else        st_q     <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign wrap_o = wrap_d;

    AST_CNT_BELOW_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, st_q.cnt} < STOP_X));                                        // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(st_q.cnt));                                       // R2
    AST_WRAP_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> ({1'b0, st_q.cnt} == START_X));                           // R4
    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !wrap_o) |=> ({1'b0, st_q.cnt} == {1'b0, $past(st_q.cnt)} + STEP_X)); // R3
endmodule

// File: rtl/nest_idx_counter.sv
module nest_idx_counter #(
    parameter int LEVELS = nic_pkg::NIC_LVLS,
    parameter int CNT_W  = nic_pkg::NIC_CNT_W,
    parameter int DATA_W = nic_pkg::NIC_DATA_W,
    parameter logic [LEVELS-1:0][31:0] LVL_START = nic_pkg::NIC_DEF_START,
    parameter logic [LEVELS-1:0][31:0] LVL_STOP  = nic_pkg::NIC_DEF_STOP,
    parameter logic [LEVELS-1:0][31:0] LVL_STEP  = nic_pkg::NIC_DEF_STEP,
    localparam int IN_BITS  = $clog2(LVL_STOP[0]),
    localparam int OUT_BITS = $clog2(LVL_STOP[LEVELS-1]),
    localparam int ADDR_W   = IN_BITS + OUT_BITS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [DATA_W-1:0]       in_data,
    output logic                    out_valid,
    output logic [DATA_W-1:0]       out_data,
    output logic [LEVELS*CNT_W-1:0] out_cnt,
    output logic [ADDR_W-1:0]       out_addr
);
    localparam int ADDR_LIMIT = (int'(LVL_STOP[LEVELS-1]) - 1) * (2 ** IN_BITS)
                              + int'(LVL_STOP[0]);

    typedef struct packed {
        logic                    valid;
        logic [DATA_W-1:0]       data;
        logic [LEVELS*CNT_W-1:0] cnt;
    } out_st_t;

    logic [LEVELS:0]         adv;
    logic [LEVELS-1:0]       wrap;
    logic [LEVELS*CNT_W-1:0] cur_cnt;
    out_st_t                 o_d, o_q;

    assign adv[0] = in_valid;

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        nic_level #(
            .CNT_W (CNT_W),
            .START (int'(LVL_START[g])),
            .STOP  (int'(LVL_STOP[g])),
            .STEP  (int'(LVL_STEP[g]))
        ) lvl_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .adv_i  (adv[g]),
            .cnt_o  (cur_cnt[g*CNT_W +: CNT_W]),
            .wrap_o (wrap[g])
        );
        assign adv[g+1] = wrap[g];
    end

    always_comb begin
        o_d       = o_q;
        o_d.valid = in_valid;
        o_d.data  = in_data;
        if (in_valid) o_d.cnt = cur_cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_valid = o_q.valid;
    assign out_data  = o_q.data;
    assign out_cnt   = o_q.cnt;
    assign out_addr  = {o_q.cnt[(LEVELS-1)*CNT_W +: OUT_BITS], o_q.cnt[0 +: IN_BITS]};

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                             // R6
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);                                           // R6
    AST_DATA_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_data == $past(in_data)));                          // R6
    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_addr) < ADDR_LIMIT));                        // R7
    AST_TAG_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_cnt == $past(cur_cnt)));                           // R8
endmodule

// File: tb/nest_idx_counter_tb_top.sv
`timescale 1ns/1ps
module nest_idx_counter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic [15:0] out_data;
    logic [59:0] out_cnt;
    logic [7:0]  out_addr;

    always #2.5 clk = ~clk;

    nest_idx_counter dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .out_cnt(out_cnt), .out_addr(out_addr)
    );

    int total = 0, bad = 0;
    int m [3];
    int ec [3];
    bit ev = 0;
    logic [15:0] ed;
    bit done = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    function automatic int fld(int i);
        return int'(out_cnt[i*20 +: 20]);
    endfunction

    task automatic model_adv();
        m[0]++;
        if (m[0] >= 2) begin
            m[0] = 0; m[1]++;
            if (m[1] >= 100) begin
                m[1] = 0; m[2]++;
                if (m[2] >= 88) m[2] = 0;
            end
        end
    endtask

    // check previous cycle's expectation, then drive the next input
    task automatic step(bit v, logic [15:0] d, string req);
        @(negedge clk);
        chk(out_valid == ev, req, "valid", out_valid, ev);
        if (ev) begin
            chk(out_data == ed, req, "data", out_data, ed);
            for (int i = 0; i < 3; i++) chk(fld(i) == ec[i], req, $sformatf("lvl%0d", i), fld(i), ec[i]);
            chk(int'(out_addr) == (ec[2] % 128) * 2 + ec[0] % 2, req, "addr",
                out_addr, (ec[2] % 128) * 2 + ec[0] % 2);
        end
        in_valid = v;
        in_data  = d;
        ev = v;
        if (v) begin
            ed = d;
            for (int i = 0; i < 3; i++) ec[i] = m[i];
            model_adv();
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && out_cnt == '0, "R1", "in reset", out_cnt, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) m[i] = 0;
        ev = 0;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "valid after reset", out_valid, 0);
        chk(out_cnt == '0, "R1", "cnt after reset", out_cnt, 0);
        step(1'b1, 16'h1234, "R1");
        step(1'b0, 16'h0, "R1");
    endtask

    task automatic t_inner();
        for (int k = 0; k < 8; k++) step(1'b1, 16'(k * 7 + 3), "R3/R7/R8");
        step(1'b0, 16'h0, "R3/R7/R8");
    endtask

    task automatic t_gaps();
        for (int k = 0; k < 40; k++) begin
            step(1'b1, 16'(k * 13), "R2");
            for (int g = 0; g < (k % 4); g++) step(1'b0, 16'hDEAD, "R2");
        end
        step(1'b0, 16'h0, "R2");
    endtask

    task automatic t_data();
        for (int k = 0; k < 12; k++)
            step(1'b1, (k % 3 == 0) ? 16'hA5A5 : (k % 3 == 1) ? 16'h0000 : 16'hFFFF, "R6");
        step(1'b0, 16'h5A5A, "R6");
    endtask

    task automatic t_full();
        do_reset();
        for (int k = 0; k < 17600; k++) step(1'b1, 16'(k), "R4/R5");
        chk(m[0] == 0 && m[1] == 0 && m[2] == 0, "R5", "model period", m[2], 0);
        step(1'b1, 16'hBEEF, "R5");
        step(1'b0, 16'h0, "R5");
        chk(fld(0) == 0 && fld(1) == 0 && fld(2) == 0, "R5", "index after period", out_cnt, 0);
    endtask

    task automatic t_midreset();
        for (int k = 0; k < 37; k++) step(1'b1, 16'(k), "R1");
        step(1'b0, 16'h0, "R1");
        do_reset();
        for (int k = 0; k < 3; k++) step(1'b1, 16'(100 + k), "R1");
        step(1'b0, 16'h0, "R1");
    endtask

    initial begin
        t_reset();
        t_inner();
        t_gaps();
        t_data();
        t_full();
        t_midreset();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule